// File: doc/BRIEF.md
# Footprint-Tracking Branch Target Buffer

This block is a direct-mapped branch target buffer for an instruction fetch unit. Each entry records which branch it holds, where that branch goes, and a two-bit direction counter. It also carries two history flags, one for the taken path and one for the fall-through path. Each fetch looks up the buffer by PC in the same cycle. The lookup returns a hit, the predicted target and the predicted direction. It also returns the history flag for the direction it predicts. A set flag means the path was fetched earlier with no instruction-cache miss since, so a mode controller outside this block can skip tag comparisons on that path.

Resolved branches come back on a separate port. A branch that resolves taken and misses in the buffer gets an entry. A branch that resolves and hits trains the entry's counter. The mode controller sets individual flags by entry index and direction. It clears all of them at once when the instruction cache misses. An allocation always clears all flags, because a replaced entry can no longer vouch for any path. When a flag write or clear falls in the same cycle as a lookup, the block raises a one-cycle stall so that fetch repeats that lookup.

Top module: `fp_btb`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports no hit, not taken and a clear flag, and `stall` is low while no lookup is presented.
- R2: A resolved taken branch that misses allocates its entry. A lookup of the same PC then hits with the resolved target and predicts taken, because the counter starts at 2.
- R3: A resolved not-taken branch that misses allocates nothing. A later lookup of that PC misses.
- R4: The counter is a 2-bit saturating counter: taken adds one up to 3, not-taken subtracts one down to 0, and values 2 and 3 predict taken.
- R5: The entry index is PC bits [7:2] and the tag is PC bits [31:8]. A PC that shares an index with a valid entry but has a different tag misses.
- R6: The `lk_foot` output is the taken-path flag when the lookup predicts taken and the fall-through flag otherwise. It is 0 on a miss, and on a miss `lk_taken` is also 0.
- R7: A set request writes 1 into only the flag chosen by its index and direction (`fp_set_taken` = 1 selects the taken path). No other flag changes.
- R8: `fp_clear` clears every flag in the buffer within one cycle.
- R9: Every allocation clears every flag. A resolve that hits and only trains a counter leaves the flags alone.
- R10: `stall` is high in exactly those cycles in which a lookup coincides with a set request, a clear, or an allocation.
- R11: A lookup in the same cycle as a flag update returns the flag value from before that update.
- R12: If a set request and a clear happen in the same cycle, the clear wins and the flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| lk_target | output | 32 | Predicted target of the indexed entry |
| lk_foot | output | 1 | History flag of the predicted path |
| stall | output | 1 | Lookup collides with a flag update and must repeat |
| fp_set_valid | input | 1 | Set one history flag |
| fp_set_idx | input | 6 | Entry index of the flag to set |
| fp_set_taken | input | 1 | 1 selects the taken flag, 0 the fall-through flag |
| fp_clear | input | 1 | Clear all history flags (instruction-cache miss) |
| rs_valid | input | 1 | A resolved branch is presented |
| rs_pc | input | 32 | PC of the resolved branch |
| rs_taken | input | 1 | Resolved direction |
| rs_target | input | 32 | Resolved target address |

## Verification
A flag left set after a clear or an allocation would show up on `lk_foot` at the next cycle's lookup of that entry. That is the costly failure, because the controller would then skip tag checks on a line that may be gone. The bench therefore reads the flags back through lookups in the cycle right after each clear, set and allocation. A counter that fails to saturate shows up on `lk_taken` a few resolves later. The saturation steps are chosen so that a counter that wraps would flip the prediction. A wrong index or tag split shows up as a false hit on an aliasing PC. The stall and the pre-update read value are both visible in the same cycle as the collision.

// File: rtl/fbtb_pkg.sv
package fbtb_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MAX   = 2'd3;
  localparam ctr_t CTR_MIN   = 2'd0;
  localparam ctr_t CTR_ALLOC = 2'd2;

  // saturating direction counter step
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t r;
    if (taken) r = (c == CTR_MAX) ? c : c + 2'd1;
    else       r = (c == CTR_MIN) ? c : c - 2'd1;
    return r;
  endfunction

  function automatic logic ctr_predict(input ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/fbtb_entry_store.sv
module fbtb_entry_store
  import fbtb_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 24,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rda_idx,
  output logic              rda_valid,
  output logic [TAG_W-1:0]  rda_tag,
  output logic [ADDR_W-1:0] rda_target,
  output ctr_t              rda_ctr,
  input  logic [IDX_W-1:0]  rdb_idx,
  output logic              rdb_valid,
  output logic [TAG_W-1:0]  rdb_tag,
  input  logic              train_en,
  input  logic              alloc_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_taken,
  input  logic [ADDR_W-1:0] wr_target
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0]        valid_vec;
  logic [ENTRIES*TAG_W-1:0]  tag_flat;
  logic [ENTRIES*ADDR_W-1:0] tgt_flat;
  logic [ENTRIES*2-1:0]      ctr_flat;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              sel;
    logic              valid_q, valid_d;
    ctr_t              ctr_q, ctr_d;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] tgt_q;
    logic              tag_we, tgt_we;

    assign sel = (wr_idx == IDX_W'(g));

    always_comb begin
      valid_d = valid_q;
      ctr_d   = ctr_q;
      tag_we  = 1'b0;
      tgt_we  = 1'b0;
      if (sel && alloc_en) begin
        valid_d = 1'b1;
        ctr_d   = CTR_ALLOC;
        tag_we  = 1'b1;
        tgt_we  = 1'b1;
      end else if (sel && train_en) begin
        ctr_d   = ctr_step(ctr_q, wr_taken);
        tgt_we  = wr_taken;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        ctr_q   <= CTR_MIN;
      end else begin
        valid_q <= valid_d;
        ctr_q   <= ctr_d;
      end
    end

    always_ff @(posedge clk) begin
      if (tag_we) tag_q <= wr_tag;
      if (tgt_we) tgt_q <= wr_target;
    end

    assign valid_vec[g]                  = valid_q;
    assign tag_flat[g*TAG_W +: TAG_W]    = tag_q;
    assign tgt_flat[g*ADDR_W +: ADDR_W]  = tgt_q;
    assign ctr_flat[g*2 +: 2]            = ctr_q;
  end

  assign rda_valid  = valid_vec[rda_idx];
  assign rda_tag    = tag_flat[rda_idx*TAG_W +: TAG_W];
  assign rda_target = tgt_flat[rda_idx*ADDR_W +: ADDR_W];
  assign rda_ctr    = ctr_flat[rda_idx*2 +: 2];
  assign rdb_valid  = valid_vec[rdb_idx];
  assign rdb_tag    = tag_flat[rdb_idx*TAG_W +: TAG_W];

endmodule

// File: rtl/fbtb_foot_store.sv
module fbtb_foot_store #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             set_taken,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_tk,
  output logic             rd_ft
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] tk_q, tk_d;
  logic [ENTRIES-1:0] ft_q, ft_d;
  logic               upd_en;

  assign upd_en = wipe | set_en;

  always_comb begin
    tk_d = tk_q;
    ft_d = ft_q;
    if (wipe) begin
      tk_d = '0;
      ft_d = '0;
    end else if (set_en) begin
      if (set_taken) tk_d[set_idx] = 1'b1;
      else           ft_d[set_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tk_q <= '0;
      ft_q <= '0;
    end else if (upd_en) begin
      tk_q <= tk_d;
      ft_q <= ft_d;
    end
  end

  assign rd_tk = tk_q[rd_idx];
  assign rd_ft = ft_q[rd_idx];

endmodule

// File: rtl/fp_btb.sv
module fp_btb
  import fbtb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_LSB = 2,
  parameter int IDX_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic              lk_taken,
  output logic [ADDR_W-1:0] lk_target,
  output logic              lk_foot,
  output logic              stall,
  input  logic              fp_set_valid,
  input  logic [IDX_W-1:0]  fp_set_idx,
  input  logic              fp_set_taken,
  input  logic              fp_clear,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_pc,
  input  logic              rs_taken,
  input  logic [ADDR_W-1:0] rs_target
);

  localparam int TAG_LSB = IDX_LSB + IDX_W;
  localparam int TAG_W   = ADDR_W - TAG_LSB;

  logic [IDX_W-1:0]  lk_idx, rs_idx;
  logic [TAG_W-1:0]  lk_tag, rs_tag;
  logic              ea_valid, eb_valid;
  logic [TAG_W-1:0]  ea_tag, eb_tag;
  logic [ADDR_W-1:0] ea_target;
  ctr_t              ea_ctr;
  logic              rs_hit, train_en, alloc_en, wipe;
  logic              foot_tk, foot_ft;
  logic              pred_tk;

  assign lk_idx = lk_pc[TAG_LSB-1:IDX_LSB];
  assign lk_tag = lk_pc[ADDR_W-1:TAG_LSB];
  assign rs_idx = rs_pc[TAG_LSB-1:IDX_LSB];
  assign rs_tag = rs_pc[ADDR_W-1:TAG_LSB];

  fbtb_entry_store #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)
  ) u_ent (
    .clk(clk), .rst_n(rst_n),
    .rda_idx(lk_idx), .rda_valid(ea_valid), .rda_tag(ea_tag),
    .rda_target(ea_target), .rda_ctr(ea_ctr),
    .rdb_idx(rs_idx), .rdb_valid(eb_valid), .rdb_tag(eb_tag),
    .train_en(train_en), .alloc_en(alloc_en),
    .wr_idx(rs_idx), .wr_tag(rs_tag), .wr_taken(rs_taken),
    .wr_target(rs_target)
  );

  // resolve side: train on hit, allocate on taken miss
  assign rs_hit   = rs_valid && eb_valid && (eb_tag == rs_tag);
  assign train_en = rs_hit;
  assign alloc_en = rs_valid && rs_taken && !rs_hit;
  assign wipe     = fp_clear || alloc_en;

  fbtb_foot_store #(
    .IDX_W(IDX_W)
  ) u_foot (
    .clk(clk), .rst_n(rst_n),
    .wipe(wipe), .set_en(fp_set_valid),
    .set_idx(fp_set_idx), .set_taken(fp_set_taken),
    .rd_idx(lk_idx), .rd_tk(foot_tk), .rd_ft(foot_ft)
  );

  // lookup side: reads registered state, so it sees pre-update values
  assign lk_hit    = lk_valid && ea_valid && (ea_tag == lk_tag);
  assign pred_tk   = ctr_predict(ea_ctr);
  assign lk_taken  = lk_hit && pred_tk;
  assign lk_target = ea_target;
  assign lk_foot   = lk_hit && (pred_tk ? foot_tk : foot_ft);
  assign stall     = lk_valid && (fp_set_valid || wipe);

endmodule

// File: rtl/fp_btb_chk.sv
module fp_btb_chk #(
  parameter int ADDR_W  = 32,
  parameter int IDX_LSB = 2,
  parameter int IDX_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_pc,
  input logic              lk_hit,
  input logic              lk_taken,
  input logic [ADDR_W-1:0] lk_target,
  input logic              lk_foot,
  input logic              stall,
  input logic              fp_set_valid,
  input logic [IDX_W-1:0]  fp_set_idx,
  input logic              fp_set_taken,
  input logic              fp_clear,
  input logic              rs_valid,
  input logic [ADDR_W-1:0] rs_pc,
  input logic              rs_taken,
  input logic [ADDR_W-1:0] rs_target
);

  localparam int TAG_LSB = IDX_LSB + IDX_W;

  assert_alloc_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && rs_taken |=>
      (!(lk_valid && lk_pc == $past(rs_pc)) ||
       (lk_hit && lk_target == $past(rs_target))));

  assert_miss_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> !lk_taken && !lk_foot);

  assert_set_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fp_set_valid && !fp_clear && !rs_valid |=>
      (!(lk_hit && lk_pc[TAG_LSB-1:IDX_LSB] == $past(fp_set_idx) &&
         lk_taken == $past(fp_set_taken)) || lk_foot));

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fp_clear |=> !lk_foot);

  assert_stall_on_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && (fp_set_valid || fp_clear) |-> stall);

  assert_no_stall_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !stall);

endmodule

bind fp_btb fp_btb_chk #(
  .ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
  .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
  .lk_foot(lk_foot), .stall(stall), .fp_set_valid(fp_set_valid),
  .fp_set_idx(fp_set_idx), .fp_set_taken(fp_set_taken),
  .fp_clear(fp_clear), .rs_valid(rs_valid), .rs_pc(rs_pc),
  .rs_taken(rs_taken), .rs_target(rs_target)
);

// File: tb/sim_fp_btb.sv
module sim_fp_btb;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        lk_valid;
  logic [31:0] lk_pc;
  logic        lk_hit, lk_taken, lk_foot, stall;
  logic [31:0] lk_target;
  logic        fp_set_valid, fp_set_taken, fp_clear;
  logic [5:0]  fp_set_idx;
  logic        rs_valid, rs_taken;
  logic [31:0] rs_pc, rs_target;

  int n_chk, n_fail;
  bit done;

  // index = pc[7:2]
  localparam logic [31:0] PA  = 32'h0000_1008; // idx 2
  localparam logic [31:0] PA2 = 32'h0000_1108; // idx 2, other tag
  localparam logic [31:0] PB  = 32'h0000_3010; // idx 4
  localparam logic [31:0] PC_ = 32'h0000_4020; // idx 8
  localparam logic [31:0] PD  = 32'h0000_6030; // idx 12

  fp_btb u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
    .lk_foot(lk_foot), .stall(stall), .fp_set_valid(fp_set_valid),
    .fp_set_idx(fp_set_idx), .fp_set_taken(fp_set_taken),
    .fp_clear(fp_clear), .rs_valid(rs_valid), .rs_pc(rs_pc),
    .rs_taken(rs_taken), .rs_target(rs_target)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 1'b0; fp_set_valid = 1'b0; fp_clear = 1'b0; rs_valid = 1'b0;
  endtask

  task automatic look(input logic [31:0] pc);
    @(negedge clk); idle();
    lk_valid = 1'b1; lk_pc = pc;
    #1;
  endtask

  task automatic resolve(input logic [31:0] pc, input logic tk,
                         input logic [31:0] tgt);
    @(negedge clk); idle();
    rs_valid = 1'b1; rs_pc = pc; rs_taken = tk; rs_target = tgt;
    @(negedge clk); idle();
  endtask

  task automatic fset(input logic [5:0] idx, input logic tk);
    @(negedge clk); idle();
    fp_set_valid = 1'b1; fp_set_idx = idx; fp_set_taken = tk;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    @(negedge clk); idle(); #1;
    chk(stall == 1'b0, "R1 stall idle", stall, 0);
    look(PA);
    chk(lk_hit == 1'b0, "R1 hit after reset", lk_hit, 0);
    chk(lk_foot == 1'b0 && lk_taken == 1'b0, "R1 foot/taken", {lk_foot, lk_taken}, 0);
  endtask

  task automatic t_alloc();
    resolve(PA, 1'b1, 32'h0000_2000);
    look(PA);
    chk(lk_hit == 1'b1, "R2 hit", lk_hit, 1);
    chk(lk_target == 32'h0000_2000, "R2 target", lk_target, 32'h2000);
    chk(lk_taken == 1'b1, "R2 taken", lk_taken, 1);
    chk(lk_foot == 1'b0, "R9 foot after alloc", lk_foot, 0);
  endtask

  task automatic t_nt_miss();
    resolve(PB, 1'b0, 32'h0000_7000);
    look(PB);
    chk(lk_hit == 1'b0, "R3 no alloc on not-taken", lk_hit, 0);
  endtask

  task automatic t_counter();
    resolve(PA, 1'b0, 32'h0); // 2->1
    look(PA);
    chk(lk_taken == 1'b0, "R4 ctr 1", lk_taken, 0);
    resolve(PA, 1'b0, 32'h0); // 0
    resolve(PA, 1'b0, 32'h0); // stays 0
    resolve(PA, 1'b1, 32'h0000_2000); // 1
    look(PA);
    chk(lk_taken == 1'b0, "R4 saturate low", lk_taken, 0);
    resolve(PA, 1'b1, 32'h0000_2000); // 2
    look(PA);
    chk(lk_taken == 1'b1, "R4 ctr 2", lk_taken, 1);
    resolve(PA, 1'b1, 32'h0000_2000); // 3
    resolve(PA, 1'b1, 32'h0000_2000); // stays 3
    resolve(PA, 1'b0, 32'h0);         // 2
    look(PA);
    chk(lk_taken == 1'b1, "R4 saturate high", lk_taken, 1);
    chk(lk_target == 32'h0000_2000, "R4 target kept on not-taken", lk_target, 32'h2000);
  endtask

  task automatic t_alias();
    look(PA2);
    chk(lk_hit == 1'b0, "R5 alias miss", lk_hit, 0);
    look(PA);
    chk(lk_hit == 1'b1, "R5 own hit", lk_hit, 1);
  endtask

  task automatic t_foot();
    resolve(PC_, 1'b1, 32'h0000_5000);
    fset(6'd2, 1'b0);
    look(PA);
    chk(lk_foot == 1'b0, "R6 taken pred reads taken flag", lk_foot, 0);
    look(PC_);
    chk(lk_foot == 1'b0, "R7 other entry untouched", lk_foot, 0);
    fset(6'd2, 1'b1);
    look(PA);
    chk(lk_foot == 1'b1, "R7 taken flag set", lk_foot, 1);
    resolve(PA, 1'b0, 32'h0); // ctr 1, predicts not taken
    look(PA);
    chk(lk_taken == 1'b0 && lk_foot == 1'b1, "R6 fall-through flag read",
        {lk_taken, lk_foot}, 1);
    resolve(PA, 1'b1, 32'h0000_2000); // back to 2, hit: no wipe
    look(PA);
    chk(lk_foot == 1'b1, "R9 training keeps flags", lk_foot, 1);
  endtask

  task automatic t_clear();
    @(negedge clk); idle(); fp_clear = 1'b1;
    @(negedge clk); idle();
    look(PA);
    chk(lk_foot == 1'b0, "R8 clear all", lk_foot, 0);
  endtask

  task automatic t_alloc_wipe();
    fset(6'd2, 1'b1);
    look(PA);
    chk(lk_foot == 1'b1, "R9 flag set before alloc", lk_foot, 1);
    resolve(PD, 1'b1, 32'h0000_8000);
    look(PA);
    chk(lk_foot == 1'b0, "R9 alloc wipes", lk_foot, 0);
  endtask

  task automatic t_collide();
    fset(6'd2, 1'b1);
    @(negedge clk); idle();
    lk_valid = 1'b1; lk_pc = PA; fp_clear = 1'b1; #1;
    chk(stall == 1'b1, "R10 stall on clear", stall, 1);
    chk(lk_foot == 1'b1, "R11 pre-clear value", lk_foot, 1);
    @(negedge clk); idle(); lk_valid = 1'b1; lk_pc = PA; #1;
    chk(stall == 1'b0, "R10 no stall plain lookup", stall, 0);
    chk(lk_foot == 1'b0, "R11 cleared after", lk_foot, 0);
    @(negedge clk); idle();
    lk_valid = 1'b1; lk_pc = PA; fp_set_valid = 1'b1; fp_set_idx = 6'd2;
    fp_set_taken = 1'b1; #1;
    chk(stall == 1'b1, "R10 stall on set", stall, 1);
    chk(lk_foot == 1'b0, "R11 pre-set value", lk_foot, 0);
    @(negedge clk); idle(); lk_valid = 1'b1; lk_pc = PA; #1;
    chk(lk_foot == 1'b1, "R11 set after", lk_foot, 1);
    @(negedge clk); idle();
    lk_valid = 1'b1; lk_pc = PA; rs_valid = 1'b1; rs_pc = 32'h0000_9040;
    rs_taken = 1'b1; rs_target = 32'h0000_A000; #1;
    chk(stall == 1'b1, "R10 stall on alloc", stall, 1);
    @(negedge clk); idle();
    fp_set_valid = 1'b1; fp_set_idx = 6'd2; fp_set_taken = 1'b1; #1;
    chk(stall == 1'b0, "R10 no stall without lookup", stall, 0);
  endtask

  task automatic t_clear_wins();
    @(negedge clk); idle();
    fp_set_valid = 1'b1; fp_set_idx = 6'd2; fp_set_taken = 1'b1; fp_clear = 1'b1;
    @(negedge clk); idle();
    look(PA);
    chk(lk_foot == 1'b0, "R12 clear beats set", lk_foot, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; idle();
    lk_pc = '0; fp_set_idx = '0; fp_set_taken = 1'b0;
    rs_pc = '0; rs_taken = 1'b0; rs_target = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_alloc();
    t_nt_miss();
    t_counter();
    t_alias();
    t_foot();
    t_clear();
    t_alloc_wipe();
    t_collide();
    t_clear_wins();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule